// File: doc/BRIEF.md
# UART Receiver with Sticky Error Lockout

This block receives asynchronous serial characters of eight data bits with one stop bit, optionally followed by an even or odd parity bit before the stop bit. The receive line is passed through two flip-flops and sampled sixteen times per bit period. Each data bit is the majority of three samples taken around the middle of the bit. A completed byte goes to a data register and sets a data-full flag. That flag drives a receive request, which an interrupt controller or a DMA engine can serve.

Three sticky error flags record overrun, parity and framing faults. While any of them is set, no new character is started. Reception resumes only after software has cleared every error. A flag is cleared by reading it as 1 in the status register and then writing 0 to its bit. The status register also shows the synchronised line level, so after a framing fault software can tell a held-low break from a single bad character. When a DMA engine reads the data register, the data-full flag clears without any software write.

Top module: `serial_rx_lockout`

## Requirements
- R1: After reset, the control register (offset 0) reads 0x00, status bits 3:0 read 0, the data register (offset 2) reads 0x00, and both request outputs are low.
- R2: With receive enabled (control bit 0), a valid character is shifted in least significant bit first. The byte is written to the data register (offset 2), and the data-full flag (status offset 1, bit 0) becomes 1.
- R3: If data-full is still 1 when a character's stop bit is sampled, the overrun flag (status bit 1) is set and the data register keeps its previous byte.
- R4: While any error flag (status bits 3:1) is 1, no character is received. Once all of them are cleared, reception resumes.
- R5: A status flag clears only when a status write puts 0 in its bit after a status read returned that bit as 1. A write without that earlier read, or a write of 1, leaves the flag unchanged.
- R6: A data-register read marked as a DMA access (rdByDma high) clears data-full. A plain processor read of the data register does not.
- R7: With parity enabled (control bit 1), the bit after the data is compared with even parity, or with odd parity when control bit 2 is 1. A mismatch sets status bit 2, and the byte is still written.
- R8: A stop-bit sample of 0 sets the framing flag (status bit 3) and the byte is still written. Status bit 4 always shows the synchronised receive line level, so a held-low break reads 0 there.
- R9: With control bit 0 clear, no character is received, and clearing that bit in the middle of a character abandons the character.
- R10: rxReqIrq is high exactly while data-full is 1 and control bit 3 is 1. errIrq is high exactly while any of status bits 3:1 is 1.
- R11: A line glitch that corrupts one of the three mid-bit samples does not change the received bit.
- R12: A low pulse shorter than half a bit that is high again at the mid-bit check of the start bit is rejected, and no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxPin | input | 1 | Serial receive line, idle high |
| regAddr | input | 2 | Register offset: 0 control, 1 status, 2 data |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Register read strobe; arms status flags and qualifies DMA reads |
| rdByDma | input | 1 | Marks the current read as a DMA access |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| rxReqIrq | output | 1 | Receive request for an interrupt or DMA engine |
| errIrq | output | 1 | Receive error request |

## Verification
The hardest state to reach from the ports is the lockout after an overrun. It takes two characters back to back with no read of data-full in between, then a DMA read that empties the register, and only then a third character that must be dropped. The bench builds this sequence out of timed line waveforms. It withholds status reads until after the unarmed clear has been tried, because any status read would arm the flags. Glitch rejection, false-start rejection and the mid-character disable each come from waveforms shaped on the bench clock, with the glitch timed to land on a single mid-bit sample.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DATA_W    = 8;
  localparam int REG_W     = 8;
  localparam int NUM_FLAGS = 4;

  localparam int FLG_FULL = 0;
  localparam int FLG_OVR  = 1;
  localparam int FLG_PAR  = 2;
  localparam int FLG_FRM  = 3;

  localparam int CTL_EN  = 0;
  localparam int CTL_PAR = 1;
  localparam int CTL_ODD = 2;
  localparam int CTL_IE  = 3;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxStateT;

  typedef struct packed {
    logic shiftEn;
    logic parityEn;
    logic frameDone;
    logic sampleVal;
  } rxStrobeT;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int TICK_DIV   = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rxPin,
  input  logic     rxEnable,
  input  logic     parityEnable,
  input  logic     errAny,
  output rxStrobeT strobes,
  output logic     rxLevel
);
  localparam int CNT_W  = $clog2(OVERSAMPLE);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0]  MID_CNT    = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0]  MID_NEXT   = CNT_W'(OVERSAMPLE / 2);
  localparam logic [CNT_W-1:0]  DECIDE_CNT = CNT_W'(OVERSAMPLE / 2 + 1);
  localparam logic [CNT_W-1:0]  LAST_CNT   = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT   = BIT_W'(DATA_W - 1);
  localparam logic [TICK_W-1:0] TICK_LAST  = TICK_W'(TICK_DIV - 1);

  logic              rxMeta, rxSync;
  logic [TICK_W-1:0] tickCnt;
  logic              tick;
  rxStateT           state;
  logic [CNT_W-1:0]  smpCnt, smpNext;
  logic [BIT_W-1:0]  bitCnt;
  logic              vote0, vote1, voteVal, decide;

  assign tick    = (tickCnt == TICK_LAST);
  assign smpNext = (smpCnt == LAST_CNT) ? '0 : smpCnt + 1'b1;
  assign voteVal = (vote0 & vote1) | (vote0 & rxSync) | (vote1 & rxSync);
  assign decide  = tick && rxEnable && (smpCnt == DECIDE_CNT);
  assign rxLevel = rxSync;

  always_comb begin
    strobes.shiftEn   = decide && (state == ST_DATA);
    strobes.parityEn  = decide && (state == ST_PAR);
    strobes.frameDone = decide && (state == ST_STOP);
    strobes.sampleVal = voteVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxMeta  <= 1'b1;
      rxSync  <= 1'b1;
      tickCnt <= '0;
      state   <= ST_IDLE;
      smpCnt  <= '0;
      bitCnt  <= '0;
      vote0   <= 1'b1;
      vote1   <= 1'b1;
    end else begin
      rxMeta  <= rxPin;
      rxSync  <= rxMeta;
      tickCnt <= tick ? '0 : tickCnt + 1'b1;
      if (!rxEnable) begin
        state  <= ST_IDLE;
        smpCnt <= '0;
      end else if (tick) begin
        if (smpCnt == MID_CNT)  vote0 <= rxSync;
        if (smpCnt == MID_NEXT) vote1 <= rxSync;
        case (state)
          ST_IDLE: begin
            smpCnt <= '0;
            if (!errAny && !rxSync) state <= ST_START;
          end
          ST_START: begin
            if (smpCnt == MID_CNT && rxSync) begin
              state  <= ST_IDLE;
              smpCnt <= '0;
            end else begin
              smpCnt <= smpNext;
              if (smpCnt == LAST_CNT) begin
                state  <= ST_DATA;
                bitCnt <= '0;
              end
            end
          end
          ST_DATA: begin
            smpCnt <= smpNext;
            if (smpCnt == LAST_CNT) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) state <= parityEnable ? ST_PAR : ST_STOP;
            end
          end
          ST_PAR: begin
            smpCnt <= smpNext;
            if (smpCnt == LAST_CNT) state <= ST_STOP;
          end
          ST_STOP: begin
            if (smpCnt == DECIDE_CNT) begin
              state  <= ST_IDLE;
              smpCnt <= '0;
            end else begin
              smpCnt <= smpNext;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_dpath.sv
module serial_rx_dpath
  import serial_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  rxStrobeT             strobes,
  input  logic                 rxLevel,
  input  logic [1:0]           regAddr,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  input  logic                 regRdEn,
  input  logic                 rdByDma,
  output logic [REG_W-1:0]     regRdData,
  output logic [NUM_FLAGS-1:0] flagBits,
  output logic                 rxEnable,
  output logic                 parityEnable,
  output logic                 rxIrqEnable
);
  logic [REG_W-1:0]     ctrlReg;
  logic [DATA_W-1:0]    shiftReg, rxData;
  logic                 parityBit, parityBad;
  logic [NUM_FLAGS-1:0] flags, flagsNext, armed, armedNext;
  logic                 wrCtrl, wrStatus, rdStatus, dmaTake;

  assign wrCtrl       = regWrEn && (regAddr == ADDR_CTRL);
  assign wrStatus     = regWrEn && (regAddr == ADDR_STAT);
  assign rdStatus     = regRdEn && (regAddr == ADDR_STAT);
  assign dmaTake      = regRdEn && rdByDma && (regAddr == ADDR_DATA);
  assign rxEnable     = ctrlReg[CTL_EN];
  assign parityEnable = ctrlReg[CTL_PAR];
  assign rxIrqEnable  = ctrlReg[CTL_IE];
  assign parityBad    = parityEnable && (parityBit != ((^shiftReg) ^ ctrlReg[CTL_ODD]));
  assign flagBits     = flags;

  always_comb begin
    flagsNext = flags;
    armedNext = armed;
    if (rdStatus) armedNext = armed | flags;
    if (wrStatus) begin
      for (int i = 0; i < NUM_FLAGS; i++) begin
        if (!regWrData[i] && armed[i]) begin
          flagsNext[i] = 1'b0;
          armedNext[i] = 1'b0;
        end
      end
    end
    if (dmaTake) flagsNext[FLG_FULL] = 1'b0;
    if (strobes.frameDone) begin
      if (flags[FLG_FULL]) begin
        flagsNext[FLG_OVR] = 1'b1;
      end else begin
        flagsNext[FLG_FULL] = 1'b1;
        if (parityBad)          flagsNext[FLG_PAR] = 1'b1;
        if (!strobes.sampleVal) flagsNext[FLG_FRM] = 1'b1;
      end
    end
    armedNext = armedNext & flagsNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg   <= '0;
      shiftReg  <= '0;
      rxData    <= '0;
      parityBit <= 1'b0;
      flags     <= '0;
      armed     <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= regWrData;
      if (strobes.shiftEn) shiftReg <= {strobes.sampleVal, shiftReg[DATA_W-1:1]};
      if (strobes.parityEn) parityBit <= strobes.sampleVal;
      if (strobes.frameDone && !flags[FLG_FULL]) rxData <= shiftReg;
      flags <= flagsNext;
      armed <= armedNext;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = ctrlReg;
      ADDR_STAT: regRdData = {{(REG_W - NUM_FLAGS - 1){1'b0}}, rxLevel, flags};
      ADDR_DATA: regRdData = rxData;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/serial_rx_lockout.sv
module serial_rx_lockout
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int TICK_DIV   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxPin,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             regRdEn,
  input  logic             rdByDma,
  output logic [REG_W-1:0] regRdData,
  output logic             rxReqIrq,
  output logic             errIrq
);
  rxStrobeT             ctlStrobes;
  logic                 rxLevel, rxEnable, parityEnable, rxIrqEnable, errAny;
  logic [NUM_FLAGS-1:0] flagBits;

  assign errAny   = flagBits[FLG_OVR] | flagBits[FLG_PAR] | flagBits[FLG_FRM];
  assign errIrq   = errAny;
  assign rxReqIrq = flagBits[FLG_FULL] & rxIrqEnable;

  serial_rx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .TICK_DIV  (TICK_DIV)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxPin       (rxPin),
    .rxEnable    (rxEnable),
    .parityEnable(parityEnable),
    .errAny      (errAny),
    .strobes     (ctlStrobes),
    .rxLevel     (rxLevel)
  );

  serial_rx_dpath u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (ctlStrobes),
    .rxLevel     (rxLevel),
    .regAddr     (regAddr),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .regRdEn     (regRdEn),
    .rdByDma     (rdByDma),
    .regRdData   (regRdData),
    .flagBits    (flagBits),
    .rxEnable    (rxEnable),
    .parityEnable(parityEnable),
    .rxIrqEnable (rxIrqEnable)
  );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
  input logic clk,
  input logic rst_n,
  input logic rxEnable,
  input logic errAny,
  input logic dataFull,
  input logic overrunErr,
  input logic frameDone,
  input logic dmaRead,
  input logic statusWrite
);
  AST_FRAME_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone && !dataFull |=> dataFull); // R2
  AST_OVERRUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone && dataFull |=> overrunErr); // R3
  AST_LOCKOUT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    errAny |-> !frameDone); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrunErr && !statusWrite |=> overrunErr); // R5
  AST_DMA_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    dmaRead && !frameDone |=> !dataFull); // R6
  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> !frameDone); // R9
endmodule

bind serial_rx_lockout serial_rx_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rxEnable   (rxEnable),
  .errAny     (errAny),
  .dataFull   (flagBits[0]),
  .overrunErr (flagBits[1]),
  .frameDone  (ctlStrobes.frameDone),
  .dmaRead    (regRdEn && rdByDma && (regAddr == 2'd2)),
  .statusWrite(regWrEn && (regAddr == 2'd1))
);

// File: tb/test_serial_rx_lockout.sv
`timescale 1ns/1ps
module test_serial_rx_lockout;
  localparam int BIT_CLKS = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxLine = 1'b1;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic       regRdEn = 1'b0;
  logic       rdByDma = 1'b0;
  logic [7:0] regRdData;
  logic       rxReqIrq, errIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit       mFull, mOv, mPe, mFe, modelValid;
  bit [3:0] mArm;
  bit [7:0] mCtrl, mData;

  always #10 clk = ~clk;

  serial_rx_lockout i_serial_rx_lockout (
    .clk(clk), .rst_n(rst_n), .rxPin(rxLine), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .rdByDma(rdByDma), .regRdData(regRdData), .rxReqIrq(rxReqIrq), .errIrq(errIrq)
  );

  function automatic bit [3:0] mFlags();
    return {mFe, mPe, mOv, mFull};
  endfunction

  function automatic bit [7:0] expStatus();
    return {3'b000, rxLine, mFe, mPe, mOv, mFull};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // reference model compared on every clock
  always @(posedge clk) begin
    #5;
    if (modelValid && rst_n && !finished) begin
      checks++;
      if (rxReqIrq !== (mFull & mCtrl[3]) || errIrq !== (mOv | mPe | mFe)) begin
        errors++;
        $display("FAIL R10 requests: actual rxReq=%0d err=%0d expected rxReq=%0d err=%0d",
                 rxReqIrq, errIrq, mFull & mCtrl[3], mOv | mPe | mFe);
      end
    end
  end

  task automatic regWrite(input bit [1:0] a, input bit [7:0] d);
    modelValid = 1'b0;
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 2'd0) mCtrl = d;
    if (a == 2'd1) begin
      if (!d[0] && mArm[0]) begin mFull = 1'b0; mArm[0] = 1'b0; end
      if (!d[1] && mArm[1]) begin mOv   = 1'b0; mArm[1] = 1'b0; end
      if (!d[2] && mArm[2]) begin mPe   = 1'b0; mArm[2] = 1'b0; end
      if (!d[3] && mArm[3]) begin mFe   = 1'b0; mArm[3] = 1'b0; end
    end
    mArm = mArm & mFlags();
    modelValid = 1'b1;
  endtask

  task automatic regRead(input bit [1:0] a, input bit dma, output bit [7:0] d);
    modelValid = 1'b0;
    @(negedge clk);
    regAddr = a; rdByDma = dma; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0; rdByDma = 1'b0;
    if (a == 2'd1) mArm = mArm | mFlags();
    if (a == 2'd2 && dma) mFull = 1'b0;
    mArm = mArm & mFlags();
    modelValid = 1'b1;
  endtask

  task automatic checkRead(input string req, input bit [1:0] a, input bit dma, input bit [7:0] exp);
    bit [7:0] v;
    regRead(a, dma, v);
    check(req, $sformatf("read offset %0d", a), v, exp);
  endtask

  task automatic checkPin(input string req, input string what, input logic act, input bit exp);
    @(negedge clk);
    #1 check(req, what, act, exp);
  endtask

  task automatic driveBit(input bit v, input bit glitch);
    rxLine = v;
    if (glitch) begin
      repeat (15) @(negedge clk);
      rxLine = ~v;
      repeat (2) @(negedge clk);
      rxLine = v;
      repeat (BIT_CLKS - 17) @(negedge clk);
    end else begin
      repeat (BIT_CLKS) @(negedge clk);
    end
  endtask

  task automatic sendRaw(input bit [7:0] d, input bit hasPar, input bit parBit,
                         input bit stopBit, input int glitchBit, input bit tailLow);
    modelValid = 1'b0;
    @(negedge clk);
    driveBit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) driveBit(d[i], i == glitchBit);
    if (hasPar) driveBit(parBit, 1'b0);
    driveBit(stopBit, 1'b0);
    rxLine = ~tailLow;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic frame(input bit [7:0] d, input bit hasPar, input bit parBit,
                       input bit stopBit, input int glitchBit, input bit tailLow);
    sendRaw(d, hasPar, parBit, stopBit, glitchBit, tailLow);
    if (mCtrl[0] && !(mOv | mPe | mFe)) begin
      if (mFull) mOv = 1'b1;
      else begin
        mFull = 1'b1;
        mData = d;
        if (mCtrl[1] && (parBit != ((^d) ^ mCtrl[2]))) mPe = 1'b1;
        if (!stopBit) mFe = 1'b1;
      end
    end
    mArm = mArm & mFlags();
    modelValid = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    modelValid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    modelValid = 1'b1;

    // R1 reset state
    checkRead("R1", 2'd0, 1'b0, 8'h00);
    checkRead("R1", 2'd1, 1'b0, 8'h10);
    checkRead("R1", 2'd2, 1'b0, 8'h00);
    checkPin("R1", "rxReqIrq", rxReqIrq, 1'b0);
    checkPin("R1", "errIrq", errIrq, 1'b0);

    // R9 receive disabled: character ignored
    frame(8'h5A, 0, 0, 1, -1, 0);
    checkRead("R9", 2'd1, 1'b0, 8'h10);
    checkRead("R9", 2'd2, 1'b0, 8'h00);

    // R2 basic reception, R10 request, R6 plain read keeps data-full
    regWrite(2'd0, 8'h09);
    frame(8'hA5, 0, 0, 1, -1, 0);
    checkRead("R2", 2'd2, 1'b0, 8'hA5);
    checkPin("R10", "rxReqIrq with full", rxReqIrq, 1'b1);
    checkRead("R6", 2'd2, 1'b0, 8'hA5);
    checkPin("R6", "full after plain read", rxReqIrq, 1'b1);
    checkRead("R6", 2'd2, 1'b1, 8'hA5);
    checkPin("R6", "full after dma read", rxReqIrq, 1'b0);

    // R2 bit order
    frame(8'h01, 0, 0, 1, -1, 0);
    checkRead("R2", 2'd2, 1'b1, 8'h01);
    frame(8'h80, 0, 0, 1, -1, 0);
    checkRead("R2", 2'd2, 1'b0, 8'h80);

    // R3 overrun
    frame(8'h3C, 0, 0, 1, -1, 0);
    checkPin("R3", "errIrq after overrun", errIrq, 1'b1);
    checkRead("R3", 2'd2, 1'b0, 8'h80);

    // R4 lockout
    checkRead("R4", 2'd2, 1'b1, 8'h80);
    frame(8'h77, 0, 0, 1, -1, 0);
    checkRead("R4", 2'd2, 1'b0, 8'h80);
    checkPin("R4", "no full during lockout", rxReqIrq, 1'b0);

    // R5 clear rules
    regWrite(2'd1, 8'h00);
    checkPin("R5", "unarmed write keeps error", errIrq, 1'b1);
    checkRead("R5", 2'd1, 1'b0, 8'h12);
    regWrite(2'd1, 8'h02);
    checkPin("R5", "write of one keeps error", errIrq, 1'b1);
    regWrite(2'd1, 8'h00);
    checkPin("R5", "armed write clears error", errIrq, 1'b0);
    checkRead("R5", 2'd1, 1'b0, 8'h10);

    // R4 resume
    frame(8'h77, 0, 0, 1, -1, 0);
    checkRead("R4", 2'd2, 1'b1, 8'h77);

    // R7 parity, even then odd
    regWrite(2'd0, 8'h0B);
    frame(8'h5B, 1, 1, 1, -1, 0);
    checkPin("R7", "even good parity", errIrq, 1'b0);
    checkRead("R7", 2'd2, 1'b1, 8'h5B);
    frame(8'hC4, 1, 0, 1, -1, 0);
    checkRead("R7", 2'd1, 1'b0, 8'h15);
    checkRead("R7", 2'd2, 1'b0, 8'hC4);
    regWrite(2'd1, 8'h01);
    checkRead("R7", 2'd1, 1'b0, 8'h11);
    checkRead("R7", 2'd2, 1'b1, 8'hC4);
    regWrite(2'd0, 8'h0F);
    frame(8'h5B, 1, 0, 1, -1, 0);
    checkPin("R7", "odd good parity", errIrq, 1'b0);
    checkRead("R7", 2'd2, 1'b1, 8'h5B);
    frame(8'h5B, 1, 1, 1, -1, 0);
    checkRead("R7", 2'd1, 1'b0, 8'h15);
    regWrite(2'd1, 8'h00);
    checkRead("R7", 2'd1, 1'b0, 8'h10);

    // R8 framing error and break level
    regWrite(2'd0, 8'h09);
    frame(8'hC3, 0, 0, 0, -1, 0);
    checkRead("R8", 2'd1, 1'b0, 8'h19);
    checkRead("R8", 2'd2, 1'b0, 8'hC3);
    regWrite(2'd1, 8'h00);
    frame(8'h00, 0, 0, 0, -1, 1);
    checkRead("R8", 2'd1, 1'b0, 8'h09);
    checkRead("R8", 2'd2, 1'b0, 8'h00);
    rxLine = 1'b1;
    repeat (5) @(negedge clk);
    checkRead("R8", 2'd1, 1'b0, 8'h19);
    regWrite(2'd1, 8'h00);
    checkRead("R8", 2'd1, 1'b0, 8'h10);

    // R11 glitch rejection
    frame(8'h00, 0, 0, 1, 3, 0);
    checkRead("R11", 2'd2, 1'b1, 8'h00);
    frame(8'hFF, 0, 0, 1, 6, 0);
    checkRead("R11", 2'd2, 1'b1, 8'hFF);

    // R12 false start
    modelValid = 1'b0;
    @(negedge clk);
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (400) @(negedge clk);
    modelValid = 1'b1;
    checkPin("R12", "no request after short pulse", rxReqIrq, 1'b0);
    checkRead("R12", 2'd1, 1'b0, 8'h10);
    frame(8'h96, 0, 0, 1, -1, 0);
    checkRead("R12", 2'd2, 1'b1, 8'h96);

    // R9 disable in mid-character
    fork
      sendRaw(8'hE1, 0, 0, 1, -1, 0);
      begin
        repeat (100) @(negedge clk);
        regWrite(2'd0, 8'h08);
      end
    join
    modelValid = 1'b1;
    checkRead("R9", 2'd1, 1'b0, 8'h10);
    regWrite(2'd0, 8'h09);
    frame(8'h1E, 0, 0, 1, -1, 0);
    checkRead("R9", 2'd2, 1'b1, 8'h1E);

    // R10 request gating
    regWrite(2'd0, 8'h01);
    frame(8'h42, 0, 0, 1, -1, 0);
    checkPin("R10", "request masked", rxReqIrq, 1'b0);
    checkRead("R10", 2'd1, 1'b0, 8'h11);
    regWrite(2'd0, 8'h09);
    checkPin("R10", "request unmasked", rxReqIrq, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule